// File: doc/BRIEF.md
# PCIe Bridge Interrupt Decode and Mask Registers

This block gathers single-cycle event pulses from a PCIe root-port bridge into a sticky 32-bit decode register and qualifies them with a 32-bit mask register. It drives a single level-sensitive interrupt line to the host CPU. The line stays high while any captured event is also enabled in the mask.

Software reaches both registers through a plain 32-bit register port. Writes are single-cycle strobes and reads are combinational. The event map is sparse and fixed. Link and error events sit in the low byte and the bits just above it. Legacy and message-signalled interrupt arrivals sit in the middle. Slave and master bus errors sit at the top. Bits outside this map do not exist. To service an interrupt, the handler reads the decode register, ANDs it with the mask, and writes the serviced bits back to acknowledge them.

Top module: `pcie_irq_decode`

## Requirements
- R1: After reset, both registers read as 0 and `irq_o` is low.
- R2: An event pulse on an implemented bit of `evt_i` sets that decode bit at the next clock edge. The bit stays set until software clears it, whatever the mask holds.
- R3: The implemented bit set is 0x1FF30FED in both the decode register and the mask register. Every other bit always reads 0 and can be set neither by an event nor by a write.
- R4: A write to the decode register, at offset 0x138, clears every decode bit whose write-data bit is 1.
- R5: Write-data bits of 0 in a write to the decode register leave the matching decode bits unchanged.
- R6: From the clock edge after a register change, `irq_o` is high exactly when (decode AND mask) is nonzero.
- R7: An event pulse in the same cycle as a write that clears that bit leaves the bit set.
- R8: The mask register, at offset 0x13C, loads the write data restricted to the implemented bits. Writing 0 to it forces `irq_o` low. Writing 0x1FF30F0D to it enables the sources that value selects.
- R9: Reads at any other offset return 0. Writes at any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one bit per decode position |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A lost or stuck decode bit shows up on the next read of offset 0x138, and through `irq_o` one cycle after the event or write that should have changed it. A mask register that holds the wrong value shows up as an interrupt line that stays high with no enabled source, or that stays low with an enabled source pending. The bench places an event and a clear in the same cycle, and it pulses all 32 event lines together, because these are the cases where an off-by-one priority or a missing bit filter would hide.

// File: rtl/pcie_irq_decode.sv
module pcie_irq_decode #(
  parameter int          AW        = 12,
  parameter int          DW        = 32,
  parameter logic [AW-1:0] DEC_OFS = 12'h138,
  parameter logic [AW-1:0] MSK_OFS = 12'h13C,
  parameter logic [DW-1:0] IMPL    = 32'h1FF3_0FED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);

  logic [DW-1:0] dec_q, msk_q;
  logic          wr_dec, wr_msk;
  logic [DW-1:0] clr_bits, set_bits;

  assign wr_dec   = reg_wr_i && (reg_addr_i == DEC_OFS);
  assign wr_msk   = reg_wr_i && (reg_addr_i == MSK_OFS);
  assign clr_bits = wr_dec ? reg_wdata_i : '0;
  assign set_bits = evt_i & IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q <= '0;
      msk_q <= '0;
    end else begin
      dec_q <= (dec_q & ~clr_bits) | set_bits;
      if (wr_msk) msk_q <= reg_wdata_i & IMPL;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == DEC_OFS)      reg_rdata_o = dec_q;
    else if (reg_addr_i == MSK_OFS) reg_rdata_o = msk_q;
  end

  assign irq_o = |(dec_q & msk_q);

  // R2
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((dec_q & $past(set_bits)) == $past(set_bits)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((dec_q & $past(clr_bits & ~evt_i)) == '0));

  // R5
  hold_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((dec_q ^ $past(dec_q)) & ~$past(clr_bits | evt_i)) == '0));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_msk)) |-> (msk_q == $past(msk_q)));

  // R3
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata_o & ~IMPL) == '0));

endmodule

// File: tb/pcie_irq_decode_tb.sv
module pcie_irq_decode_tb_top;

  localparam logic [11:0] DEC = 12'h138;
  localparam logic [11:0] MSK = 12'h13C;
  localparam logic [1:0] OP_EVT = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  DEC,    32'h0,          32'h0,          4'd1}, // R1
    '{OP_RD,  MSK,    32'h0,          32'h0,          4'd1}, // R1
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd1}, // R1
    '{OP_EVT, DEC,    32'hFFFF_FFFF,  32'h0,          4'd2}, // R2
    '{OP_RD,  DEC,    32'h0,          32'h1FF3_0FED,  4'd3}, // R3
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd2}, // R2 mask zero
    '{OP_WR,  MSK,    32'hFFFF_FFFF,  32'h0,          4'd8}, // R8
    '{OP_RD,  MSK,    32'h0,          32'h1FF3_0FED,  4'd3}, // R3
    '{OP_IRQ, DEC,    32'h0,          32'h1,          4'd6}, // R6
    '{OP_WR,  MSK,    32'h0,          32'h0,          4'd8}, // R8
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd8}, // R8
    '{OP_WR,  MSK,    32'h1FF3_0F0D,  32'h0,          4'd8}, // R8
    '{OP_RD,  MSK,    32'h0,          32'h1FF3_0F0D,  4'd8}, // R8
    '{OP_IRQ, DEC,    32'h0,          32'h1,          4'd6}, // R6
    '{OP_WR,  DEC,    32'h0000_0F00,  32'h0,          4'd4}, // R4
    '{OP_RD,  DEC,    32'h0,          32'h1FF3_00ED,  4'd4}, // R4
    '{OP_WR,  DEC,    32'h0,          32'h0,          4'd5}, // R5
    '{OP_RD,  DEC,    32'h0,          32'h1FF3_00ED,  4'd5}, // R5
    '{OP_WR,  DEC,    32'hFFFF_FFFF,  32'h0,          4'd4}, // R4
    '{OP_RD,  DEC,    32'h0,          32'h0,          4'd4}, // R4
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd6}, // R6
    '{OP_EVT, DEC,    32'h0000_0020,  32'h0,          4'd2}, // R2
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd6}, // R6 masked bit
    '{OP_EVT, DEC,    32'h0001_0000,  32'h0,          4'd2}, // R2
    '{OP_RD,  DEC,    32'h0,          32'h0001_0020,  4'd2}, // R2
    '{OP_IRQ, DEC,    32'h0,          32'h1,          4'd6}, // R6
    '{OP_RD,  12'h130, 32'h0,         32'h0,          4'd9}, // R9
    '{OP_WR,  DEC,    32'h0001_0000,  32'h0,          4'd4}, // R4
    '{OP_IRQ, DEC,    32'h0,          32'h0,          4'd6}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_i, reg_wdata_i, reg_rdata_o;
  logic        reg_wr_i, irq_o;
  logic [11:0] reg_addr_i;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pcie_irq_decode dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d; evt_i = e;
    @(negedge clk);
    reg_wr_i = 1'b0; evt_i = '0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      case (VEC[i].op)
        OP_EVT: cycle(1'b0, VEC[i].addr, '0, VEC[i].data);
        OP_WR:  cycle(1'b1, VEC[i].addr, VEC[i].data, '0);
        OP_RD:  read_chk(tag, VEC[i].addr, VEC[i].exp);
        default: begin #1; check(tag, {31'b0, irq_o}, VEC[i].exp); end
      endcase
    end

    // R7: clear and event on the same bit in one cycle; bit 5 cleared, bit 17 survives
    cycle(1'b0, DEC, '0, 32'h0000_0020);
    cycle(1'b1, DEC, 32'h0002_0020, 32'h0002_0000);
    read_chk("R7", DEC, 32'h0002_0000);
    #1; check("R7", {31'b0, irq_o}, 32'h1);

    // R9: write at a foreign offset leaves both registers as they were
    cycle(1'b1, 12'h13C + 12'h8, 32'hFFFF_FFFF, '0);
    read_chk("R9", DEC, 32'h0002_0000);
    read_chk("R9", MSK, 32'h1FF3_0F0D);

    // R1: mid-run reset returns everything to zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_chk("R1", DEC, 32'h0);
    read_chk("R1", MSK, 32'h0);
    #1; check("R1", {31'b0, irq_o}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule